// File: doc/BRIEF.md
# DRAM Refresh Scheduler with Postponement

This block tells a DDR SDRAM command scheduler when an AUTO REFRESH is owed. A free-running interval counter adds one refresh credit each refresh interval. Credits accumulate while the scheduler is busy, so refreshes can be postponed. The stored count saturates at eight, which is the most a device allows to be owed. The count drives a normal request. Once seven or more credits are owed, an urgent request is also raised, and all other traffic is held off until the backlog has shrunk.

When the scheduler grants a refresh, the block removes one credit. It then holds a refresh-in-progress flag for exactly the refresh recovery time, and blocks new commands for that time. The block also runs the self-refresh handshake. While the device refreshes itself, CKE is driven low, the interval counter is frozen and the credit count is cleared. After the device wakes up, non-read commands and reads are released after separate delays.

All timings are parameters expressed in clock cycles. Every output depends only on registered state.

Top module: `dram_refresh_sched`

## Requirements
- R1: Outside self refresh, one credit is added every INTERVAL_CYC cycles. After reset is released, `ref_req` first rises after INTERVAL_CYC clock edges.
- R2: `ref_req` is high exactly when credits are owed, no recovery is in progress, the block is not in self refresh, and non-read commands are open.
- R3: The stored credit count saturates at MAX_OWED (8). A tick with no grant at the limit changes nothing. A tick and an accepted grant in the same cycle leave the count unchanged.
- R4: `ref_urgent` is high while `ref_req` is high and URGENT_AT (7) or more credits are owed. While it is high, `cmd_ok` and `rd_ok` are low.
- R5: A grant taken while `ref_req` is high removes one credit. `ref_busy` is then high for exactly RFC_CYC cycles, starting on the next cycle. During that time `ref_req`, `cmd_ok` and `rd_ok` are low.
- R6: `cke` is low only in self refresh. `sr_enter` is taken only when the block is running normally, no recovery is in progress, and no grant is taken in the same cycle.
- R7: In self refresh, the credit count is cleared, the interval counter holds its value, and `ref_req` stays low.
- R8: After `sr_exit` is taken, `cmd_ok` and `ref_req` stay low for XSNR_CYC cycles.
- R9: After `sr_exit` is taken, `rd_ok` stays low for XSRD_CYC cycles. Normal operation then resumes.
- R10: While reset is held, and just after it: `ref_req`, `ref_urgent` and `ref_busy` are 0, and `cke`, `cmd_ok` and `rd_ok` are 1.
- R11: The following inputs have no effect on any output: a grant while `ref_req` is low, `sr_exit` outside self refresh, and `sr_enter` during recovery or wake-up.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_grant | input | 1 | Scheduler issues the requested refresh this cycle |
| sr_enter | input | 1 | Request to enter self refresh |
| sr_exit | input | 1 | Request to leave self refresh |
| ref_req | output | 1 | Refresh owed and may be issued |
| ref_urgent | output | 1 | Postponement limit is near; refresh first |
| ref_busy | output | 1 | Refresh recovery in progress |
| cke | output | 1 | Clock enable to the device |
| cmd_ok | output | 1 | Non-read commands may be issued |
| rd_ok | output | 1 | Reads may be issued |

## Verification
A wrong credit count shows up as a misplaced edge on `ref_req` or `ref_urgent`. Such a count can come from a lost saturation, a double decrement, or a count that is not cleared in self refresh. The misplaced edge appears no later than the next grant or interval tick. A recovery or wake-up counter that is off by one shows up as a `ref_busy`, `cmd_ok` or `rd_ok` window that is one cycle too short or too long, on the very next refresh or wake-up. A mode register stuck in the wrong state shows up at once on `cke`. For these reasons, every output is compared against an independent cycle model on every cycle.

// File: rtl/refsched_pkg.sv
package refsched_pkg;
  typedef enum logic [1:0] {
    PM_RUN  = 2'd0,
    PM_SELF = 2'd1,
    PM_WAKE = 2'd2
  } pm_mode_t;
endpackage

// File: rtl/ref_credit.sv
module ref_credit #(
  parameter int INTERVAL_CYC = 780,
  parameter int MAX_OWED     = 8,
  localparam int TW = $clog2(INTERVAL_CYC),
  localparam int OW = $clog2(MAX_OWED + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run_en,
  input  logic          clear,
  input  logic          take,
  output logic [OW-1:0] owed,
  output logic          tick
);
  logic [TW-1:0] tick_cnt;

  assign tick = run_en && (tick_cnt == TW'(INTERVAL_CYC - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_cnt <= '0;
      owed     <= '0;
    end else begin
      if (run_en) tick_cnt <= tick ? '0 : tick_cnt + 1'b1;
      if (clear) owed <= '0;
      else if (tick && !take && owed != OW'(MAX_OWED)) owed <= owed + 1'b1;
      else if (take && !tick) owed <= owed - 1'b1;
    end
  end

  p_sat_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (owed == OW'(MAX_OWED) && tick && !take && !clear) |=> owed == OW'(MAX_OWED));
  p_take_dec_r5: assert property (@(posedge clk) disable iff (rst)
    (take && !tick && !clear) |=> owed == $past(owed) - 1'b1);
  p_frozen_r7: assert property (@(posedge clk) disable iff (rst)
    !run_en |=> tick_cnt == $past(tick_cnt));
  p_tick_add_r1: assert property (@(posedge clk) disable iff (rst)
    (tick && !take && !clear && owed < OW'(MAX_OWED)) |=> owed == $past(owed) + 1'b1);
endmodule

// File: rtl/ref_recovery.sv
module ref_recovery #(
  parameter int RFC_CYC = 8,
  localparam int RW = $clog2(RFC_CYC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic take,
  output logic busy
);
  logic [RW-1:0] rcnt;

  assign busy = (rcnt != '0);

  always_ff @(posedge clk) begin
    if (rst) rcnt <= '0;
    else if (take) rcnt <= RW'(RFC_CYC);
    else if (busy) rcnt <= rcnt - 1'b1;
  end

  p_busy_load_r5: assert property (@(posedge clk) disable iff (rst)
    take |=> rcnt == RW'(RFC_CYC));
  p_busy_count_r5: assert property (@(posedge clk) disable iff (rst)
    (busy && !take) |=> rcnt == $past(rcnt) - 1'b1);
endmodule

// File: rtl/ref_power.sv
module ref_power
  import refsched_pkg::*;
#(
  parameter int XSNR_CYC = 8,
  parameter int XSRD_CYC = 200,
  localparam int WW = $clog2(XSRD_CYC)
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     sr_go,
  input  logic     sr_exit,
  output pm_mode_t mode,
  output logic     nonrd_open
);
  logic [WW-1:0] wake_cnt;
  logic          wake_last;

  assign wake_last  = (wake_cnt == WW'(XSRD_CYC - 1));
  assign nonrd_open = (mode == PM_WAKE) && (wake_cnt >= WW'(XSNR_CYC));

  always_ff @(posedge clk) begin
    if (rst) begin
      mode     <= PM_RUN;
      wake_cnt <= '0;
    end else begin
      unique case (mode)
        PM_RUN:  if (sr_go) mode <= PM_SELF;
        PM_SELF: if (sr_exit) begin
          mode     <= PM_WAKE;
          wake_cnt <= '0;
        end
        PM_WAKE: begin
          if (wake_last) begin
            mode     <= PM_RUN;
            wake_cnt <= '0;
          end else begin
            wake_cnt <= wake_cnt + 1'b1;
          end
        end
        default: mode <= PM_RUN;
      endcase
    end
  end

  p_self_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (mode == PM_SELF && !sr_exit) |=> mode == PM_SELF);
  p_wake_stay_r9: assert property (@(posedge clk) disable iff (rst)
    (mode == PM_WAKE && !wake_last) |=> mode == PM_WAKE);
  p_wake_done_r9: assert property (@(posedge clk) disable iff (rst)
    (mode == PM_WAKE && wake_last) |=> mode == PM_RUN);
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import refsched_pkg::*;
#(
  parameter int INTERVAL_CYC = 780,
  parameter int RFC_CYC      = 8,
  parameter int MAX_OWED     = 8,
  parameter int URGENT_AT    = 7,
  parameter int XSNR_CYC     = 8,
  parameter int XSRD_CYC     = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_grant,
  input  logic sr_enter,
  input  logic sr_exit,
  output logic ref_req,
  output logic ref_urgent,
  output logic ref_busy,
  output logic cke,
  output logic cmd_ok,
  output logic rd_ok
);
  localparam int OW = $clog2(MAX_OWED + 1);

  pm_mode_t      mode;
  logic          nonrd_open;
  logic [OW-1:0] owed;
  logic          tick;
  logic          take;
  logic          sr_go;
  logic          open_nr;

  assign open_nr    = (mode == PM_RUN) || nonrd_open;
  assign ref_req    = (mode != PM_SELF) && (owed != '0) && !ref_busy && open_nr;
  assign ref_urgent = ref_req && (owed >= OW'(URGENT_AT));
  assign take       = ref_grant && ref_req;
  assign sr_go      = sr_enter && (mode == PM_RUN) && !ref_busy && !take;
  assign cke        = (mode != PM_SELF);
  assign cmd_ok     = !ref_busy && !ref_urgent && open_nr;
  assign rd_ok      = !ref_busy && !ref_urgent && (mode == PM_RUN);

  ref_credit #(.INTERVAL_CYC(INTERVAL_CYC), .MAX_OWED(MAX_OWED)) u_credit (
    .clk(clk), .rst(rst),
    .run_en(mode != PM_SELF),
    .clear(sr_go || mode == PM_SELF),
    .take(take), .owed(owed), .tick(tick)
  );

  ref_recovery #(.RFC_CYC(RFC_CYC)) u_recov (
    .clk(clk), .rst(rst), .take(take), .busy(ref_busy)
  );

  ref_power #(.XSNR_CYC(XSNR_CYC), .XSRD_CYC(XSRD_CYC)) u_power (
    .clk(clk), .rst(rst), .sr_go(sr_go), .sr_exit(sr_exit),
    .mode(mode), .nonrd_open(nonrd_open)
  );

  p_cke_busy_r6: assert property (@(posedge clk) disable iff (rst)
    ref_busy |-> cke);
  p_urgent_block_r4: assert property (@(posedge clk) disable iff (rst)
    ref_urgent |-> (!cmd_ok && !rd_ok));
  p_self_empty_r7: assert property (@(posedge clk) disable iff (rst)
    (mode == PM_SELF) |-> (owed == '0 && !ref_req));
  p_wake_rd_r9: assert property (@(posedge clk) disable iff (rst)
    (mode == PM_WAKE) |-> !rd_ok);
  p_grant_busy_r5: assert property (@(posedge clk) disable iff (rst)
    take |=> (ref_busy && !ref_req && !cmd_ok));
endmodule

// File: tb/dram_refresh_sched_test.sv
module dram_refresh_sched_test;
  localparam int CLK_PERIOD = 10;
  localparam int INTERVAL = 40;
  localparam int RFC = 5;
  localparam int MAXO = 8;
  localparam int URG = 7;
  localparam int XSNR = 4;
  localparam int XSRD = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_grant = 1'b0, sr_enter = 1'b0, sr_exit = 1'b0;
  logic ref_req, ref_urgent, ref_busy, cke, cmd_ok, rd_ok;
  int   n_run = 0, n_fail = 0;
  logic [5:0] exp_q[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  dram_refresh_sched #(
    .INTERVAL_CYC(INTERVAL), .RFC_CYC(RFC), .MAX_OWED(MAXO),
    .URGENT_AT(URG), .XSNR_CYC(XSNR), .XSRD_CYC(XSRD)
  ) uut (
    .clk(clk), .rst(rst), .ref_grant(ref_grant), .sr_enter(sr_enter),
    .sr_exit(sr_exit), .ref_req(ref_req), .ref_urgent(ref_urgent),
    .ref_busy(ref_busy), .cke(cke), .cmd_ok(cmd_ok), .rd_ok(rd_ok)
  );

  task automatic chk(input string tag, input int got, input int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // Reference model built from the requirements; mode 0 run, 1 self, 2 wake
  int m_mode = 0, m_tick = 0, m_owed = 0, m_busy = 0, m_wake = 0;
  always begin
    bit open, req, take, tck, go, urg;
    @(posedge clk);
    if (rst) begin
      m_mode = 0; m_tick = 0; m_owed = 0; m_busy = 0; m_wake = 0;
    end else begin
      open = (m_mode == 0) || (m_mode == 2 && m_wake >= XSNR);
      req  = (m_mode != 1) && (m_owed > 0) && (m_busy == 0) && open;
      take = ref_grant && req;
      tck  = (m_mode != 1) && (m_tick == INTERVAL - 1);
      go   = sr_enter && (m_mode == 0) && (m_busy == 0) && !take;
      if (m_mode != 1) m_tick = tck ? 0 : m_tick + 1;
      if (go || m_mode == 1) m_owed = 0;
      else if (tck && !take) m_owed = (m_owed < MAXO) ? m_owed + 1 : MAXO;
      else if (take && !tck) m_owed = m_owed - 1;
      if (take) m_busy = RFC;
      else if (m_busy > 0) m_busy = m_busy - 1;
      case (m_mode)
        0: if (go) m_mode = 1;
        1: if (sr_exit) begin m_mode = 2; m_wake = 0; end
        default: if (m_wake == XSRD - 1) begin m_mode = 0; m_wake = 0; end
                 else m_wake = m_wake + 1;
      endcase
    end
    open = (m_mode == 0) || (m_mode == 2 && m_wake >= XSNR);
    req  = (m_mode != 1) && (m_owed > 0) && (m_busy == 0) && open;
    urg  = req && (m_owed >= URG);
    exp_q.push_back({req, urg, (m_busy > 0), (m_mode != 1),
                     (m_busy == 0) && !urg && open,
                     (m_busy == 0) && !urg && (m_mode == 0)});
  end

  // Monitor: compare every cycle away from the active edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [5:0] e;
      e = exp_q.pop_front();
      chk("R2 ref_req", ref_req, e[5]);
      chk("R4 ref_urgent", ref_urgent, e[4]);
      chk("R5 ref_busy", ref_busy, e[3]);
      chk("R6 cke", cke, e[2]);
      chk("R8 cmd_ok", cmd_ok, e[1]);
      chk("R9 rd_ok", rd_ok, e[0]);
    end
  end

  task automatic grant_one();
    while (!ref_req) @(negedge clk);
    ref_grant = 1'b1;
    @(negedge clk);
    ref_grant = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    chk("R10 reset ref_req", ref_req, 0);
    chk("R10 reset ref_urgent", ref_urgent, 0);
    chk("R10 reset ref_busy", ref_busy, 0);
    chk("R10 reset cke", cke, 1);
    chk("R10 reset cmd_ok", cmd_ok, 1);
    chk("R10 reset rd_ok", rd_ok, 1);
    rst = 1'b0;
    cnt = 0;
    forever begin
      @(negedge clk);
      if (ref_req) break;
      cnt++;
    end
    chk("R1 first request delay", cnt, INTERVAL - 1);
    // R5: one grant, recovery length
    ref_grant = 1'b1;
    @(negedge clk);
    ref_grant = 1'b0;
    cnt = 0;
    while (ref_busy) begin cnt++; @(negedge clk); end
    chk("R5 recovery cycles", cnt, RFC);
    // R11: grant with nothing owed
    ref_grant = 1'b1; idle(3); ref_grant = 1'b0;
    chk("R11 stray grant busy", ref_busy, 0);
    // R3/R4: let credits pile up past the limit
    idle(INTERVAL * 10);
    chk("R4 urgent at limit", ref_urgent, 1);
    chk("R4 cmd blocked", cmd_ok, 0);
    repeat (3) grant_one();
    chk("R3 after 3 grants not urgent", ref_urgent, 0);
    repeat (3) grant_one();
    // R11/R6: self refresh request during recovery is ignored
    grant_one();
    sr_enter = 1'b1; @(negedge clk); sr_enter = 1'b0;
    chk("R6 enter during busy ignored", cke, 1);
    while (ref_busy) @(negedge clk);
    sr_exit = 1'b1; @(negedge clk); sr_exit = 1'b0;
    chk("R11 exit while running ignored", rd_ok, 1);
    // R6/R7: self refresh
    sr_enter = 1'b1; @(negedge clk); sr_enter = 1'b0;
    chk("R6 cke low in self refresh", cke, 0);
    idle(INTERVAL * 3);
    chk("R7 no request in self refresh", ref_req, 0);
    sr_exit = 1'b1; @(negedge clk); sr_exit = 1'b0;
    cnt = 1;
    sr_enter = 1'b1;
    while (!cmd_ok) begin cnt++; @(negedge clk); end
    sr_enter = 1'b0;
    chk("R8 non-read hold-off", cnt - 1, XSNR);
    while (!rd_ok) begin cnt++; @(negedge clk); end
    chk("R9 read hold-off", cnt - 1, XSRD);
    chk("R11 enter during wake ignored", cke, 1);
    // steady operation with grants as requests come
    repeat (4) grant_one();
    idle(INTERVAL * 2);
    sr_enter = 1'b1; @(negedge clk); sr_enter = 1'b0;
    idle(7);
    sr_exit = 1'b1; @(negedge clk); sr_exit = 1'b0;
    idle(XSRD + INTERVAL);
    grant_one();
    idle(RFC + 3);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL R1 watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule